// File: doc/BRIEF.md
# Board Control Register Block with Card-Detect Status

This block is a small set of board-control registers on a 32-bit, word-indexed register bus. Two of its words are constant: an identification word and an address-decode word. A third word is a placeholder for flash programming control, and it reads zero. The fourth word is a card-slot status register. It shows the live level of the slot's write-protect switch. It also keeps a sticky flag that records a card-insert event.

The sticky flag drives an interrupt line directly. Software reads the status word to see why the interrupt was raised. It then writes a one to the flag's bit position to release the line. A new insert event in the same cycle as that clear wins, so an event is never lost. An access to any index outside the four defined words reads zero and raises a one-cycle error flag.

Bus timing: a request is sampled on a rising clock edge. Read data and the error flag appear in the cycle after the request. The read data is zero whenever no read was requested in the previous cycle. Register writes take effect at the edge that samples them.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, the card-insert flag is clear, `card_irq` is 0, `bus_rdata` is 0 and `bus_err` is 0.
- R2: A read of index 0 returns 0x41034003. A read of index 1 returns 0. A read of index 3 returns 0x11. The data appears on `bus_rdata` one cycle after the request, and `bus_rdata` is 0 in any cycle that follows no read.
- R3: A read of index 2 returns the `wp_level` input in bit 0, as sampled in the request cycle. Bits other than 0 and 3 read as 0.
- R4: When `card_evt` is high at a clock edge, the card-insert flag (bit 3 of index 2) is set from the next cycle. It stays set after `card_evt` returns low.
- R5: A write to index 2 with data bit 3 set clears the card-insert flag from the next cycle. A write to index 2 with data bit 3 clear changes nothing, whatever the other data bits are.
- R6: `card_irq` always equals the card-insert flag, and a read of index 2 reports that flag in bit 3.
- R7: Writes to indices 0, 1 and 3 are accepted and change no register and no output.
- R8: If `card_evt` is high in the same cycle as a clearing write to index 2, the flag is set (or stays set).
- R9: A read or write of any index of 4 or above gives `bus_err` high for exactly the following cycle. A read of such an index returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle error for an undefined index |
| wp_level | input | 1 | Write-protect switch level |
| card_evt | input | 1 | Card-insert event, level-sampled each edge |
| card_irq | output | 1 | Interrupt, equal to the card-insert flag |

## Verification
The bench builds the block with its default parameters: a 6-bit index, so 60 of the 64 indices are undefined. This reaches high undefined indices such as 63. It also reaches aliasing indices such as 6, whose two low bits match the status word; an incomplete decode would wrongly clear the flag there. The default constants and bit positions fix the expected ID and decode words and the status-word layout. With them, the clear-versus-insert collision and the ignored data bits can be driven and checked at exact positions.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_WORDS  = 4;
  localparam int unsigned IX_IDENT   = 0;
  localparam int unsigned IX_FLASH   = 1;
  localparam int unsigned IX_SLOT    = 2;
  localparam int unsigned IX_DECODE  = 3;
  localparam int unsigned WP_POS     = 0;
  localparam int unsigned CD_POS     = 3;

  typedef struct packed {
    logic ident;
    logic flash;
    logic slot;
    logic decode;
    logic miss;
  } word_hit_t;
endpackage

// File: rtl/board_ctl_rst_sync.sv
module board_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  output word_hit_t        hit
);
  localparam logic [IDX_W-1:0] K_IDENT  = IDX_W'(IX_IDENT);
  localparam logic [IDX_W-1:0] K_FLASH  = IDX_W'(IX_FLASH);
  localparam logic [IDX_W-1:0] K_SLOT   = IDX_W'(IX_SLOT);
  localparam logic [IDX_W-1:0] K_DECODE = IDX_W'(IX_DECODE);

  always_comb begin
    hit        = '0;
    hit.ident  = sel && (idx == K_IDENT);
    hit.flash  = sel && (idx == K_FLASH);
    hit.slot   = sel && (idx == K_SLOT);
    hit.decode = sel && (idx == K_DECODE);
    hit.miss   = sel && !(hit.ident || hit.flash || hit.slot || hit.decode);
  end
endmodule

// File: rtl/board_ctl_slot_status.sv
module board_ctl_slot_status
  import board_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wp_level,
  input  logic              card_evt,
  output logic              cd_flag,
  output logic [WORD_W-1:0] stat_word
);
  logic cd_q;
  logic cd_d;
  logic cd_en;
  logic clr_req;

  always_comb begin
    clr_req = slot_wr && wdata[CD_POS];
    cd_en   = card_evt || clr_req;
    cd_d    = cd_q;
    if (card_evt)     cd_d = 1'b1;
    else if (clr_req) cd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cd_q <= 1'b0;
    else if (cd_en) cd_q <= cd_d;
  end

  always_comb begin
    stat_word         = '0;
    stat_word[WP_POS] = wp_level;
    stat_word[CD_POS] = cd_q;
  end

  assign cd_flag = cd_q;
endmodule

// File: rtl/board_ctl_resp.sv
module board_ctl_resp
  import board_ctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [WORD_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  word_hit_t         hit,
  input  logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] rdata,
  output logic              err
);
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              err_d, err_q;

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      unique case (1'b1)
        hit.ident:  rdata_d = ID_VALUE;
        hit.slot:   rdata_d = stat_word;
        hit.decode: rdata_d = DECODE_VALUE;
        default:    rdata_d = '0;
      endcase
    end
    err_d = hit.miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int unsigned       IDX_W        = 6,
  parameter int unsigned       SYNC_STAGES  = 2,
  parameter logic [WORD_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [WORD_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              wp_level,
  input  logic              card_evt,
  output logic              card_irq
);
  logic              rst_sync_n;
  word_hit_t         hit;
  logic [WORD_W-1:0] stat_word;
  logic              cd_flag;
  logic              rd_req;
  logic              slot_wr;

  board_ctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  board_ctl_decode #(.IDX_W(IDX_W)) u_dec (
    .sel (bus_sel),
    .idx (bus_idx),
    .hit (hit)
  );

  assign rd_req  = bus_sel && !bus_wr;
  assign slot_wr = hit.slot && bus_wr;

  board_ctl_slot_status u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot_wr   (slot_wr),
    .wdata     (bus_wdata),
    .wp_level  (wp_level),
    .card_evt  (card_evt),
    .cd_flag   (cd_flag),
    .stat_word (stat_word)
  );

  board_ctl_resp #(.ID_VALUE(ID_VALUE), .DECODE_VALUE(DECODE_VALUE)) u_resp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd        (rd_req),
    .hit       (hit),
    .stat_word (stat_word),
    .rdata     (bus_rdata),
    .err       (bus_err)
  );

  assign card_irq = cd_flag;
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk
  import board_ctl_pkg::*;
#(
  parameter int unsigned       IDX_W        = 6,
  parameter logic [WORD_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [WORD_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              wp_level,
  input logic              card_evt,
  input logic              card_irq
);
  localparam logic [IDX_W-1:0] K_TWO  = IDX_W'(IX_SLOT);
  localparam logic [IDX_W-1:0] K_ZERO = IDX_W'(IX_IDENT);
  localparam logic [IDX_W-1:0] K_LIM  = IDX_W'(NUM_WORDS);

  logic clr_wr;
  assign clr_wr = bus_sel && bus_wr && (bus_idx == K_TWO) && bus_wdata[CD_POS];

  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!card_irq && !bus_err && bus_rdata == '0));

  p_ident_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_idx == K_ZERO) |=> (bus_rdata == ID_VALUE));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (bus_rdata == '0 && !bus_err));

  p_wp_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_idx == K_TWO) |=> (bus_rdata[WP_POS] == $past(wp_level)));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_evt |=> card_irq);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_irq && !clr_wr) |=> card_irq);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !card_evt) |=> !card_irq);

  p_flag_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_idx == K_TWO) |=> (bus_rdata[CD_POS] == $past(card_irq)));

  p_miss_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_idx >= K_LIM) |=> (bus_err && bus_rdata == '0));

  p_no_spurious_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_idx < K_LIM) |=> !bus_err);
endmodule

bind board_ctl_regs board_ctl_regs_chk #(
  .IDX_W(IDX_W), .ID_VALUE(ID_VALUE), .DECODE_VALUE(DECODE_VALUE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_idx   (bus_idx),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .wp_level  (wp_level),
  .card_evt  (card_evt),
  .card_irq  (card_irq)
);

// File: tb/board_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module board_ctl_regs_tb_top;
  localparam int IDX_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [IDX_W-1:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        wp_level = 1'b0;
  logic        card_evt = 1'b0;
  logic        card_irq;

  int n_checks = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  board_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .wp_level(wp_level), .card_evt(card_evt),
    .card_irq(card_irq)
  );

  // behavioural reference model
  int          settle = 0;
  bit          m_flag = 0;
  logic [31:0] m_rdata = 0;
  bit          m_err = 0;

  always @(posedge clk) begin
    logic [31:0] rv;
    if (!rst_n) begin
      settle = 0; m_flag = 0; m_rdata = 0; m_err = 0;
    end else if (settle < 2) begin
      settle++; m_flag = 0; m_rdata = 0; m_err = 0;
    end else begin
      rv = 0;
      if (bus_sel && !bus_wr) begin
        if (bus_idx == 0)      rv = 32'h4103_4003;
        else if (bus_idx == 2) rv = {28'd0, m_flag, 2'b00, wp_level};
        else if (bus_idx == 3) rv = 32'h11;
      end
      m_rdata = rv;
      m_err   = bus_sel && (int'(bus_idx) >= 4);
      if (card_evt) m_flag = 1;
      else if (bus_sel && bus_wr && bus_idx == 2 && bus_wdata[3]) m_flag = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk({cur_tag, " rdata"}, bus_rdata, m_rdata);
    chk({cur_tag, " err"}, {31'd0, bus_err}, {31'd0, m_err});
    chk({cur_tag, " R6 irq"}, {31'd0, card_irq}, {31'd0, m_flag});
  endtask

  task automatic acc(input bit wr, input int idx, input logic [31:0] wd);
    bus_sel = 1; bus_wr = wr; bus_idx = IDX_W'(idx); bus_wdata = wd;
    tick();
    bus_sel = 0; bus_wr = 0; bus_idx = '0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 irq", {31'd0, card_irq}, 32'd0);
    chk("R1 err", {31'd0, bus_err}, 32'd0);
    cur_tag = "R1";
    acc(0, 2, 0); chk("R1 status", bus_rdata, 32'd0);

    cur_tag = "R2";
    acc(0, 0, 0); chk("R2 ident", bus_rdata, 32'h4103_4003);
    acc(0, 1, 0); chk("R2 flash", bus_rdata, 32'd0);
    acc(0, 3, 0); chk("R2 decode", bus_rdata, 32'h11);
    idle(1);      chk("R2 idle", bus_rdata, 32'd0);

    cur_tag = "R3";
    wp_level = 1; acc(0, 2, 0); chk("R3 wp high", bus_rdata, 32'h1);
    wp_level = 0; acc(0, 2, 0); chk("R3 wp low", bus_rdata, 32'h0);

    cur_tag = "R4";
    card_evt = 1; tick(); card_evt = 0;
    chk("R4 set", {31'd0, card_irq}, 32'd1);
    idle(3);
    wp_level = 1; acc(0, 2, 0); chk("R4 sticky", bus_rdata, 32'h9);

    cur_tag = "R5";
    acc(1, 2, 32'hFFFF_FFF7); chk("R5 no clear", {31'd0, card_irq}, 32'd1);
    acc(1, 2, 32'h0000_0008); chk("R5 clear", {31'd0, card_irq}, 32'd0);
    acc(0, 2, 0); chk("R5 readback", bus_rdata, 32'h1);

    cur_tag = "R8";
    card_evt = 1; acc(1, 2, 32'h8); card_evt = 0;
    chk("R8 set wins", {31'd0, card_irq}, 32'd1);
    card_evt = 1; acc(1, 2, 32'h8); card_evt = 0;
    chk("R8 stays", {31'd0, card_irq}, 32'd1);

    cur_tag = "R7";
    acc(1, 0, 32'hFFFF_FFFF);
    acc(1, 1, 32'hFFFF_FFFF);
    acc(1, 3, 32'hFFFF_FFFF);
    chk("R7 irq kept", {31'd0, card_irq}, 32'd1);
    acc(0, 0, 0); chk("R7 ident", bus_rdata, 32'h4103_4003);
    acc(0, 3, 0); chk("R7 decode", bus_rdata, 32'h11);
    acc(0, 2, 0); chk("R7 status", bus_rdata, 32'h9);

    cur_tag = "R9";
    acc(0, 4, 0);  chk("R9 err4", {31'd0, bus_err}, 32'd1); chk("R9 data4", bus_rdata, 0);
    idle(1);       chk("R9 one cycle", {31'd0, bus_err}, 32'd0);
    acc(0, 63, 0); chk("R9 err63", {31'd0, bus_err}, 32'd1);
    acc(0, 6, 0);  chk("R9 alias6", bus_rdata, 32'd0);
    acc(1, 6, 32'h8); chk("R9 write err", {31'd0, bus_err}, 32'd1);
    chk("R9 no clear", {31'd0, card_irq}, 32'd1);
    acc(1, 2, 32'h8); chk("R5 final clear", {31'd0, card_irq}, 32'd0);

    cur_tag = "R6";
    for (int k = 0; k < 20; k++) begin
      card_evt = (k % 7) == 3;
      wp_level = k[0];
      acc(k % 3 == 0, k % 5, (k % 2) ? 32'h8 : 32'h0);
    end
    card_evt = 0;
    idle(2);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule